// File: doc/BRIEF.md
# Stereo Audio Serial Port, Left-Justified Master

The block is the master end of a two-channel serial audio link to a DAC and an ADC. From a base clock and a bit-rate enable pulse supplied by a separate divider, it generates the bit clock and the frame clock. It sends 16-bit playback samples and receives 16-bit record samples in a left-justified format. The frame clock runs at the sample rate. Its rising edge opens the left channel and its falling edge opens the right channel. The most significant bit goes in the first bit slot after each frame-clock edge, with no one-slot delay.

Playback pairs are taken from a producer through a valid/ready handshake. The ready strobe comes one bit-clock period before the left MSB is due. If no pair is offered, the previous pair is sent again and an underrun pulse is raised. Record data is assembled into pairs. A pair is offered to a consumer with a valid flag that stays up until it is accepted. A pair that completes while the previous one is still waiting is dropped, and an overrun pulse is raised. A mode input selects 32 or 64 bit-clock periods per channel half, which is 64 or 128 times the sample rate.

Top module: `asp_port`

## Requirements
- R1: While enabled, the first frame-clock transition is low-to-high, so the left channel is sent first. It happens on a bit-clock falling edge.
- R2: Bits sent while the frame clock is high belong to the left sample. Bits sent after a high-to-low transition belong to the right sample.
- R3: Each sample is sent MSB first. The MSB is in slot 0, the first bit-clock period after the frame-clock edge.
- R4: Slots 0 to 15 of a half carry the sample. The remaining slots of that half drive serial out low, and serial-in bits received in those slots do not change the received pair.
- R5: A channel half lasts 32 bit-clock periods when `wide_mode`=0 and 64 when `wide_mode`=1. The bit clock toggles only on a `bit_tick` cycle, so one bit-clock period is two ticks. `wide_mode` must stay constant while `en` is high.
- R6: The frame clock and serial out change only on bit-clock falling edges. Serial in is sampled on bit-clock rising edges, so a direct loopback returns the transmitted pair unchanged.
- R7: `tx_ready_o` is a one-cycle strobe. It is raised one bit-clock period (two ticks) before each left-channel MSB is launched, and the pair is taken in that cycle if `tx_valid_i` is high.
- R8: If `tx_valid_i` is low at a strobe, the previous pair is sent again and `tx_underrun_o` pulses high for one cycle in the following cycle.
- R9: `rx_valid_o` rises only after both the left and right 16 bits of a frame have been captured. The pair holds steady until `rx_ready_i` is seen, and `rx_valid_o` then drops.
- R10: If a pair completes while `rx_valid_o` is high and `rx_ready_i` is low, the new pair is discarded, the held pair is unchanged, and `rx_overrun_o` pulses one cycle later.
- R11: After reset, and two cycles after `en` goes low, `sclk_o`, `lrck_o` and `sdout_o` are low. After reset, `rx_valid_o` and `tx_ready_o` are also low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Port enable; low holds the serial side idle |
| bit_tick | input | 1 | One-cycle pulse at twice the bit-clock rate |
| wide_mode | input | 1 | 0: 32 slots per half (64 fs); 1: 64 slots per half (128 fs) |
| tx_valid_i | input | 1 | Playback pair offered |
| tx_left_i | input | 16 | Playback left sample |
| tx_right_i | input | 16 | Playback right sample |
| tx_ready_o | output | 1 | Playback pair taken this cycle |
| tx_underrun_o | output | 1 | Pulse: no pair at a fetch, previous pair reused |
| sclk_o | output | 1 | Bit clock |
| lrck_o | output | 1 | Frame clock, high for left |
| sdout_o | output | 1 | Serial playback data |
| sdin_i | input | 1 | Serial record data |
| rx_valid_o | output | 1 | Record pair available |
| rx_ready_i | input | 1 | Consumer accepts the record pair |
| rx_left_o | output | 16 | Record left sample |
| rx_right_o | output | 16 | Record right sample |
| rx_overrun_o | output | 1 | Pulse: completed pair dropped |

## Verification
Serial out is looped back to serial in. The port is then driven with sample pairs of all zeros, all ones, alternating bits, a lone MSB, a lone LSB and mixed words, in both slot modes. Words whose halves differ expose channel swaps, bit reversal and a one-slot delay, and the single-bit words expose MSB/LSB slot misplacement. Some runs force the padding slots high on the input, which shows whether those bits leak into the received pair. A directed sequence withholds both the producer and the consumer to provoke the repeat-on-underrun and drop-on-overrun paths. Distinct successive pairs show which pair was kept and which was resent. Disabling the port in the middle of a frame and enabling it again checks the idle levels and that the next frame starts with the left channel.

// File: rtl/asp_pkg.sv
package asp_pkg;

  // Channel carried by a half-frame; the left half is sent first in every frame.
  typedef enum logic {
    CH_LEFT  = 1'b0,
    CH_RIGHT = 1'b1
  } ch_e;

  function automatic ch_e other_ch(input ch_e c);
    return (c == CH_LEFT) ? CH_RIGHT : CH_LEFT;
  endfunction

endpackage

// File: rtl/asp_frame_timer.sv
// Bit clock, frame clock and slot position. A launch event is a bit-clock
// falling edge (or the priming tick after enable); a capture event is a
// bit-clock rising edge.
module asp_frame_timer #(
  parameter int SLOTS_NARROW = 32,
  parameter int SLOTS_WIDE   = 64,
  parameter int SLOT_W       = $clog2(SLOTS_WIDE)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                bit_tick,
  input  logic                wide_mode,
  output logic                sclk_o,
  output logic                lrck_o,
  output logic                launch_o,
  output asp_pkg::ch_e        launch_ch_o,
  output logic [SLOT_W-1:0]   launch_slot_o,
  output logic                capture_o,
  output asp_pkg::ch_e        capture_ch_o,
  output logic [SLOT_W-1:0]   capture_slot_o,
  output logic                fetch_o
);
  import asp_pkg::*;

  logic              primed_q;
  logic              sclk_q;
  logic              lrck_q;
  ch_e               ch_q;
  logic [SLOT_W-1:0] slot_q;

  logic [SLOT_W-1:0] last_slot;
  ch_e               ch_nx;
  logic [SLOT_W-1:0] slot_nx;

  assign last_slot = wide_mode ? SLOT_W'(SLOTS_WIDE - 1) : SLOT_W'(SLOTS_NARROW - 1);

  always_comb begin
    ch_nx   = ch_q;
    slot_nx = slot_q;
    if (primed_q) begin
      if (slot_q == last_slot) begin
        slot_nx = '0;
        ch_nx   = other_ch(ch_q);
      end else begin
        slot_nx = slot_q + 1'b1;
      end
    end
  end

  assign launch_o       = en && bit_tick && (!primed_q || sclk_q);
  assign capture_o      = en && bit_tick && primed_q && !sclk_q;
  assign launch_ch_o    = ch_nx;
  assign launch_slot_o  = slot_nx;
  assign capture_ch_o   = ch_q;
  assign capture_slot_o = slot_q;
  // Fetch when the last right slot is launched: one bit period ahead of the left MSB.
  assign fetch_o        = launch_o && (ch_nx == CH_RIGHT) && (slot_nx == last_slot);

  always_ff @(posedge clk) begin
    if (rst || !en) begin
      primed_q <= 1'b0;
      sclk_q   <= 1'b0;
      lrck_q   <= 1'b0;
      ch_q     <= CH_RIGHT;
      slot_q   <= last_slot;
    end else if (bit_tick) begin
      if (primed_q) sclk_q <= !sclk_q;
      if (launch_o) begin
        primed_q <= 1'b1;
        ch_q     <= ch_nx;
        slot_q   <= slot_nx;
        lrck_q   <= (ch_nx == CH_LEFT);
      end
    end
  end

  assign sclk_o = sclk_q;
  assign lrck_o = lrck_q;

endmodule

// File: rtl/asp_tx_path.sv
// Playback pair holding register and serial bit selection.
module asp_tx_path #(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                launch,
  input  asp_pkg::ch_e        launch_ch,
  input  logic [SLOT_W-1:0]   launch_slot,
  input  logic                fetch,
  input  logic                tx_valid,
  input  logic [SAMPLE_W-1:0] tx_left,
  input  logic [SAMPLE_W-1:0] tx_right,
  output logic                tx_ready,
  output logic                sdout_o,
  output logic                underrun_o
);
  import asp_pkg::*;

  localparam int IDX_W = (SAMPLE_W > 1) ? $clog2(SAMPLE_W) : 1;

  logic [SAMPLE_W-1:0] left_q;
  logic [SAMPLE_W-1:0] right_q;
  logic                sdout_q;
  logic                underrun_q;
  logic [SAMPLE_W-1:0] word;
  logic [IDX_W-1:0]    idx;
  logic                bit_nx;

  assign tx_ready = fetch;

  always_comb begin
    word   = (launch_ch == CH_LEFT) ? left_q : right_q;
    idx    = IDX_W'(SAMPLE_W - 1 - int'(launch_slot));
    bit_nx = (int'(launch_slot) < SAMPLE_W) ? word[idx] : 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q     <= '0;
      right_q    <= '0;
      sdout_q    <= 1'b0;
      underrun_q <= 1'b0;
    end else begin
      underrun_q <= fetch && !tx_valid;
      if (fetch && tx_valid) begin
        left_q  <= tx_left;
        right_q <= tx_right;
      end
      if (!en)         sdout_q <= 1'b0;
      else if (launch) sdout_q <= bit_nx;
    end
  end

  assign sdout_o    = sdout_q;
  assign underrun_o = underrun_q;

endmodule

// File: rtl/asp_rx_path.sv
// Record shift register, pair assembly and output hold with drop-on-full.
module asp_rx_path #(
  parameter int SAMPLE_W = 16,
  parameter int SLOT_W   = 6
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                capture,
  input  asp_pkg::ch_e        capture_ch,
  input  logic [SLOT_W-1:0]   capture_slot,
  input  logic                sdin,
  input  logic                rx_ready,
  output logic                rx_valid,
  output logic [SAMPLE_W-1:0] rx_left,
  output logic [SAMPLE_W-1:0] rx_right,
  output logic                overrun_o
);
  import asp_pkg::*;

  logic [SAMPLE_W-1:0] sr_q;
  logic [SAMPLE_W-1:0] left_hold_q;
  logic                left_ok_q;
  logic                valid_q;
  logic [SAMPLE_W-1:0] out_l_q;
  logic [SAMPLE_W-1:0] out_r_q;
  logic                overrun_q;

  logic                in_data;
  logic                word_done;
  logic [SAMPLE_W-1:0] word_nx;

  assign in_data   = capture && (int'(capture_slot) < SAMPLE_W);
  assign word_done = in_data && (capture_slot == SLOT_W'(SAMPLE_W - 1));
  assign word_nx   = {sr_q[SAMPLE_W-2:0], sdin};

  always_ff @(posedge clk) begin
    if (rst) begin
      sr_q        <= '0;
      left_hold_q <= '0;
      left_ok_q   <= 1'b0;
      valid_q     <= 1'b0;
      out_l_q     <= '0;
      out_r_q     <= '0;
      overrun_q   <= 1'b0;
    end else begin
      overrun_q <= 1'b0;
      if (valid_q && rx_ready) valid_q <= 1'b0;
      if (!en) begin
        sr_q      <= '0;
        left_ok_q <= 1'b0;
      end else if (in_data) begin
        sr_q <= word_nx;
        if (word_done) begin
          if (capture_ch == CH_LEFT) begin
            left_hold_q <= word_nx;
            left_ok_q   <= 1'b1;
          end else if (left_ok_q) begin
            left_ok_q <= 1'b0;
            if (valid_q && !rx_ready) begin
              overrun_q <= 1'b1;
            end else begin
              out_l_q <= left_hold_q;
              out_r_q <= word_nx;
              valid_q <= 1'b1;
            end
          end
        end
      end
    end
  end

  assign rx_valid  = valid_q;
  assign rx_left   = out_l_q;
  assign rx_right  = out_r_q;
  assign overrun_o = overrun_q;

endmodule

// File: rtl/asp_port.sv
module asp_port #(
  parameter int SAMPLE_W     = 16,
  parameter int SLOTS_NARROW = 32,
  parameter int SLOTS_WIDE   = 64
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                en,
  input  logic                bit_tick,
  input  logic                wide_mode,
  input  logic                tx_valid_i,
  input  logic [SAMPLE_W-1:0] tx_left_i,
  input  logic [SAMPLE_W-1:0] tx_right_i,
  output logic                tx_ready_o,
  output logic                tx_underrun_o,
  output logic                sclk_o,
  output logic                lrck_o,
  output logic                sdout_o,
  input  logic                sdin_i,
  output logic                rx_valid_o,
  input  logic                rx_ready_i,
  output logic [SAMPLE_W-1:0] rx_left_o,
  output logic [SAMPLE_W-1:0] rx_right_o,
  output logic                rx_overrun_o
);
  import asp_pkg::*;

  localparam int SLOT_W = $clog2(SLOTS_WIDE);

  logic              launch;
  ch_e               launch_ch;
  logic [SLOT_W-1:0] launch_slot;
  logic              capture;
  ch_e               capture_ch;
  logic [SLOT_W-1:0] capture_slot;
  logic              fetch;

  asp_frame_timer #(
    .SLOTS_NARROW(SLOTS_NARROW),
    .SLOTS_WIDE  (SLOTS_WIDE),
    .SLOT_W      (SLOT_W)
  ) timer_i (
    .clk           (clk),
    .rst           (rst),
    .en            (en),
    .bit_tick      (bit_tick),
    .wide_mode     (wide_mode),
    .sclk_o        (sclk_o),
    .lrck_o        (lrck_o),
    .launch_o      (launch),
    .launch_ch_o   (launch_ch),
    .launch_slot_o (launch_slot),
    .capture_o     (capture),
    .capture_ch_o  (capture_ch),
    .capture_slot_o(capture_slot),
    .fetch_o       (fetch)
  );

  asp_tx_path #(
    .SAMPLE_W(SAMPLE_W),
    .SLOT_W  (SLOT_W)
  ) tx_i (
    .clk        (clk),
    .rst        (rst),
    .en         (en),
    .launch     (launch),
    .launch_ch  (launch_ch),
    .launch_slot(launch_slot),
    .fetch      (fetch),
    .tx_valid   (tx_valid_i),
    .tx_left    (tx_left_i),
    .tx_right   (tx_right_i),
    .tx_ready   (tx_ready_o),
    .sdout_o    (sdout_o),
    .underrun_o (tx_underrun_o)
  );

  asp_rx_path #(
    .SAMPLE_W(SAMPLE_W),
    .SLOT_W  (SLOT_W)
  ) rx_i (
    .clk         (clk),
    .rst         (rst),
    .en          (en),
    .capture     (capture),
    .capture_ch  (capture_ch),
    .capture_slot(capture_slot),
    .sdin        (sdin_i),
    .rx_ready    (rx_ready_i),
    .rx_valid    (rx_valid_o),
    .rx_left     (rx_left_o),
    .rx_right    (rx_right_o),
    .overrun_o   (rx_overrun_o)
  );

endmodule

// File: rtl/asp_port_chk.sv
module asp_port_chk #(
  parameter int SAMPLE_W = 16
) (
  input logic                clk,
  input logic                rst,
  input logic                en,
  input logic                bit_tick,
  input logic                wide_mode,
  input logic                tx_valid_i,
  input logic                tx_ready_o,
  input logic                tx_underrun_o,
  input logic                sclk_o,
  input logic                lrck_o,
  input logic                sdout_o,
  input logic                rx_valid_o,
  input logic                rx_ready_i,
  input logic [SAMPLE_W-1:0] rx_left_o,
  input logic [SAMPLE_W-1:0] rx_right_o,
  input logic                rx_overrun_o
);

  // R6: frame clock moves only with a bit-clock fall
  p_lrck_on_fall_r6: assert property (@(posedge clk) disable iff (rst || !en)
    ($past(en) && !$stable(lrck_o)) |-> $fell(sclk_o));

  // R6: serial out moves only with a bit-clock fall
  p_sdout_on_fall_r6: assert property (@(posedge clk) disable iff (rst || !en)
    ($past(en) && !$stable(sdout_o)) |-> $fell(sclk_o));

  // R5: bit clock paced by the tick input
  p_sclk_paced_r5: assert property (@(posedge clk) disable iff (rst || !en)
    ($past(en) && !$stable(sclk_o)) |-> $past(bit_tick));

  // R5: slot mode held while running
  p_mode_hold_r5: assert property (@(posedge clk) disable iff (rst)
    (en && $past(en)) |-> $stable(wide_mode));

  // R7: fetch strobe lasts one cycle
  p_ready_pulse_r7: assert property (@(posedge clk) disable iff (rst)
    tx_ready_o |=> !tx_ready_o);

  // R8: underrun only after a strobe with nothing offered
  p_underrun_cause_r8: assert property (@(posedge clk) disable iff (rst)
    tx_underrun_o |-> $past(tx_ready_o && !tx_valid_i));

  // R9: held pair stays put until taken
  p_rx_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (rx_valid_o && !rx_ready_i) |=> (rx_valid_o && $stable(rx_left_o) && $stable(rx_right_o)));

  // R10: overrun only while a pair was waiting
  p_no_overrun_r10: assert property (@(posedge clk) disable iff (rst)
    rx_overrun_o |-> ($past(rx_valid_o && !rx_ready_i) && rx_valid_o));

  // R11: idle levels while disabled
  p_idle_r11: assert property (@(posedge clk) disable iff (rst)
    (!en && $past(!en)) |-> (!sclk_o && !lrck_o && !sdout_o));

endmodule

bind asp_port asp_port_chk #(.SAMPLE_W(SAMPLE_W)) chk_i (.*);

// File: tb/asp_port_tb.sv
module asp_port_tb_top;

  localparam int DIV  = 2;
  localparam int NV   = 8;
  localparam int WDOG = 150000;

  // {wide_mode, pad_junk, left, right}
  localparam logic [33:0] VEC [NV] = '{
    {1'b0, 1'b0, 16'h0000, 16'hFFFF},
    {1'b0, 1'b1, 16'hAAAA, 16'h5555},
    {1'b0, 1'b0, 16'h8000, 16'h0001},
    {1'b0, 1'b1, 16'h1234, 16'hABCD},
    {1'b1, 1'b0, 16'hFFFF, 16'h0000},
    {1'b1, 1'b1, 16'h0001, 16'h8000},
    {1'b1, 1'b0, 16'hC3A5, 16'h5A3C},
    {1'b1, 1'b1, 16'h7FFE, 16'h0F0F}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        en = 1'b0;
  logic        bit_tick = 1'b0;
  logic        wide_mode = 1'b0;
  logic        tx_valid = 1'b0;
  logic [15:0] tx_left = '0;
  logic [15:0] tx_right = '0;
  logic        rx_ready = 1'b0;
  logic        junk = 1'b0;
  logic        tx_ready, tx_underrun, sclk, lrck, sdout, sdin;
  logic        rx_valid, rx_overrun;
  logic [15:0] rx_left, rx_right;

  int n_checks = 0;
  int n_fail   = 0;
  int cyc      = 0;
  int tcnt     = 0;

  // monitor state
  logic        m_seen = 1'b0, m_prev_sclk = 1'b0, m_prev_lrck = 1'b0, m_pad = 1'b0;
  int          m_slot = 0, m_err = 0, fetch_cyc = 0;
  logic [15:0] exp_l = '0, exp_r = '0, pend_l = '0, pend_r = '0;
  logic        seen_u = 1'b0, seen_o = 1'b0;

  always #2.5 clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (tcnt == DIV - 1) begin tcnt <= 0; bit_tick <= 1'b1; end
    else begin tcnt <= tcnt + 1; bit_tick <= 1'b0; end
  end

  assign sdin = sdout | (junk & m_pad);

  asp_port dut_i (
    .clk(clk), .rst(rst), .en(en), .bit_tick(bit_tick), .wide_mode(wide_mode),
    .tx_valid_i(tx_valid), .tx_left_i(tx_left), .tx_right_i(tx_right),
    .tx_ready_o(tx_ready), .tx_underrun_o(tx_underrun),
    .sclk_o(sclk), .lrck_o(lrck), .sdout_o(sdout), .sdin_i(sdin),
    .rx_valid_o(rx_valid), .rx_ready_i(rx_ready),
    .rx_left_o(rx_left), .rx_right_o(rx_right), .rx_overrun_o(rx_overrun)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint expv);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, expv);
    end
  endtask

  // Serial monitor: slot counting, half length, bit content, fetch timing.
  always @(negedge clk) begin
    if (tx_underrun) seen_u = 1'b1;
    if (rx_overrun)  seen_o = 1'b1;
    if (rst || !en) begin
      m_seen = 1'b0; m_prev_sclk = 1'b0; m_prev_lrck = 1'b0;
      m_slot = 0; m_err = 0; m_pad = 1'b0;
    end else begin
      if (tx_ready) begin
        fetch_cyc = cyc;
        if (tx_valid) begin pend_l = tx_left; pend_r = tx_right; end
      end
      if (m_prev_sclk && !sclk) begin
        if (lrck != m_prev_lrck) begin
          if (m_seen) begin
            check(m_slot + 1 == (wide_mode ? 64 : 32), "R5 half-frame length", m_slot + 1, wide_mode ? 64 : 32);
            check(m_err == 0, "R2 R3 R4 serial bits of half", m_err, 0);
          end else begin
            check(lrck == 1'b1, "R1 first half is left", lrck, 1);
          end
          if (lrck) begin
            check(cyc - fetch_cyc == 2 * DIV + 1, "R7 fetch lead before left MSB", cyc - fetch_cyc, 2 * DIV + 1);
            exp_l = pend_l; exp_r = pend_r;
          end
          m_seen = 1'b1; m_slot = 0; m_err = 0;
        end else begin
          m_slot++;
        end
        if (m_seen) begin
          if (m_slot < 16) begin
            if (sdout != (lrck ? exp_l[15 - m_slot] : exp_r[15 - m_slot])) m_err++;
          end else if (sdout != 1'b0) m_err++;
        end
      end
      m_pad = m_seen && (m_slot >= 16);
      m_prev_sclk = sclk;
      m_prev_lrck = lrck;
    end
  end

  task automatic wait_ready();
    int g = 0;
    while (!tx_ready && g < 2000) begin @(negedge clk); g++; end
  endtask

  task automatic wait_rx();
    int g = 0;
    while (!rx_valid && g < 4000) begin @(negedge clk); g++; end
  endtask

  task automatic start_port(input logic m, input logic j);
    en = 1'b0;
    @(negedge clk);
    if (rx_valid) begin rx_ready = 1'b1; @(negedge clk); rx_ready = 1'b0; end
    repeat (3) @(negedge clk);
    wide_mode = m; junk = j; seen_u = 1'b0; seen_o = 1'b0;
    en = 1'b1;
  endtask

  task automatic run_vector(input logic m, input logic j, input logic [15:0] l, input logic [15:0] r);
    tx_left = l; tx_right = r; tx_valid = 1'b1; rx_ready = 1'b0;
    start_port(m, j);
    wait_ready();
    @(negedge clk);
    tx_valid = 1'b0;
    wait_rx();
    check(rx_valid && rx_left == l, "R6 R9 R4 loopback left", rx_left, l);
    check(rx_right == r, "R6 R9 R4 loopback right", rx_right, r);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    check(!rx_valid, "R9 valid drops after accept", rx_valid, 0);
    repeat ((m ? 64 : 32) * 2 * 2 * DIV) @(negedge clk);
    en = 1'b0;
  endtask

  initial begin
    repeat (WDOG) @(posedge clk);
    n_checks++; n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R11 reset state
    check(!sclk, "R11 reset sclk", sclk, 0);
    check(!lrck, "R11 reset lrck", lrck, 0);
    check(!sdout, "R11 reset sdout", sdout, 0);
    check(!rx_valid, "R11 reset rx_valid", rx_valid, 0);
    check(!tx_ready, "R11 reset tx_ready", tx_ready, 0);

    for (int i = 0; i < NV; i++)
      run_vector(VEC[i][33], VEC[i][32], VEC[i][31:16], VEC[i][15:0]);

    // R8 / R10: pair A, then B, then nothing; consumer stalled.
    tx_left = 16'hA5C3; tx_right = 16'h3C5A; tx_valid = 1'b1; rx_ready = 1'b0;
    start_port(1'b0, 1'b0);
    wait_ready();
    @(negedge clk);
    tx_left = 16'h1EE7; tx_right = 16'hBEEF;
    wait_ready();
    @(negedge clk);
    tx_valid = 1'b0;
    wait_rx();
    check(rx_left == 16'hA5C3 && rx_right == 16'h3C5A, "R9 first pair", rx_left, 16'hA5C3);
    check(!seen_u, "R8 no underrun while supplied", seen_u, 0);
    begin
      int g = 0;
      while (!seen_o && g < 4000) begin @(negedge clk); g++; end
    end
    check(seen_o, "R10 overrun flagged", seen_o, 1);
    check(rx_valid && rx_left == 16'hA5C3 && rx_right == 16'h3C5A, "R10 held pair kept", rx_right, 16'h3C5A);
    rx_ready = 1'b1;
    @(negedge clk);
    rx_ready = 1'b0;
    wait_rx();
    check(seen_u, "R8 underrun flagged", seen_u, 1);
    check(rx_left == 16'h1EE7 && rx_right == 16'hBEEF, "R8 previous pair resent", rx_left, 16'h1EE7);

    // R11 disable mid-frame, then R1 restart
    repeat (37) @(negedge clk);
    en = 1'b0;
    repeat (2) @(negedge clk);
    check(!sclk && !lrck && !sdout, "R11 idle after disable", {sclk, lrck, sdout}, 0);
    run_vector(1'b1, 1'b0, 16'h0FF0, 16'hF00F);

    $display("[TB] %0d tests run, %0d failed", n_checks, n_fail);
    $finish;
  end

endmodule